// File: doc/BRIEF.md
# Bit-Serial Exact Divide-by-Three Converter

This block divides an unsigned operand by three when the operand is known to be an exact multiple of three. The dividend arrives one bit per accepted clock, least significant bit first. The quotient leaves at the same rate, also least significant bit first. No adder or subtractor chain is used. A three-state machine tracks the pending borrow of the identity q = N − 2q. Each quotient bit is the incoming bit, inverted while the machine sits in the middle state.

A word is `WIDTH` accepted bits long. After the last bit the machine checks its terminal state. Any state other than the idle one means the dividend was not a multiple of three, and the sticky flag `ndiv_o` is raised. When one word ends, the next accepted bit starts a new word from the idle state. A `start_i` strobe abandons a partial word and clears the flag at any time. Software or a surrounding datapath uses `q_last_o` to find the word boundary.

Top module: `serial_div3_exact`

## Requirements
- R1: While reset is held, and in the first cycle after it, `q_vld_o`, `q_last_o` and `ndiv_o` are 0.
- R2: The states are encoded on two bits: idle 00, middle 01, high 11. The transitions are as follows. From idle, input 0 stays in idle and input 1 moves to middle. From middle, input 0 moves to high and input 1 returns to idle. From high, input 0 moves to middle and input 1 stays in high. The quotient bit equals the input bit, except in middle, where it is the inverted input bit.
- R3: Each cycle with `bit_vld_i` high produces exactly one quotient bit on `q_o`, with `q_vld_o` high, in the following cycle. A cycle with `bit_vld_i` low produces `q_vld_o` low and advances neither the state nor the bit position.
- R4: For a dividend that is a multiple of three, the `WIDTH` quotient bits, read least significant first, equal the dividend divided by three. Bit `WIDTH-1` of that quotient is 0.
- R5: `ndiv_o` is updated in the same cycle as the last quotient bit of a word. It is set to 1 when the terminal state is not idle (the dividend is not a multiple of three) and to 0 otherwise. It holds its value until the next word ends or `start_i` is seen.
- R6: `start_i` returns the machine to idle and the bit position to 0, and clears `ndiv_o` in the following cycle. A bit accepted in the same cycle as `start_i` is bit 0 of the new word.
- R7: `q_last_o` is high together with `q_vld_o` for the `WIDTH`-th quotient bit of each word and low otherwise. The bit after it begins a new word from idle without any strobe.
- R8: For any dividend, the quotient equals the dividend multiplied by the inverse of three modulo 2^`WIDTH` (171 for `WIDTH`=8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Abandon the current word, return to idle, clear the flag |
| bit_vld_i | input | 1 | Dividend bit on `bit_i` is accepted this cycle |
| bit_i | input | 1 | Dividend bit, least significant first |
| q_vld_o | output | 1 | Quotient bit on `q_o` is valid |
| q_o | output | 1 | Quotient bit, least significant first |
| q_last_o | output | 1 | Marks the final quotient bit of a word |
| ndiv_o | output | 1 | Last completed word was not a multiple of three |

## Verification
A wrong state register or transition shows up at the ports within one accepted bit. The next quotient bit comes out with the wrong polarity whenever the state is wrongly taken to be middle, or wrongly taken not to be. A transition error that leaves the polarity right for a while still moves the terminal state off idle. That error is caught no later than the word's last bit, as a false `ndiv_o`. A stalled or skipped bit position misplaces `q_last_o` inside the same word. The full 8-bit sweep compares every quotient against the modular-inverse product, so each transition is exercised from each state.

// File: rtl/serdiv3_pkg.sv
package serdiv3_pkg;

   // Borrow-tracking states, encoding (x,y); 2'b10 is unreachable
   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_MID  = 2'b01,
      ST_HIGH = 2'b11
   } div3_state_e;

   // Quotient bit is inverted only in the middle state
   function automatic logic flip_of(input div3_state_e s);
      return (s == ST_MID);
   endfunction

endpackage

// File: rtl/serdiv3_step.sv
module serdiv3_step
   import serdiv3_pkg::*;
#(
   parameter int STYLE = 0   // 0: state table, 1: two-variable equations
) (
   input  div3_state_e cur_i,
   input  logic        din_i,
   output div3_state_e nxt_o,
   output logic        qbit_o
);

   initial begin
      assert (STYLE == 0 || STYLE == 1)
         else $error("serdiv3_step: STYLE must be 0 or 1");
   end

   generate
      if (STYLE == 0) begin : g_table
         always_comb begin
            qbit_o = din_i ^ flip_of(cur_i);
            unique case (cur_i)
               ST_IDLE: nxt_o = din_i ? ST_MID  : ST_IDLE;
               ST_MID:  nxt_o = din_i ? ST_IDLE : ST_HIGH;
               ST_HIGH: nxt_o = din_i ? ST_HIGH : ST_MID;
               default: nxt_o = ST_IDLE;
            endcase
         end
      end else begin : g_eqn
         logic sx, sy, nx, ny;
         always_comb begin
            sx     = cur_i[1];
            sy     = cur_i[0];
            nx     = sy & ~(sx ^ din_i);
            ny     = sx | (sy ^ din_i);
            nxt_o  = div3_state_e'({nx, ny});
            qbit_o = din_i ^ (sy & ~sx);
         end
      end
   endgenerate

endmodule

// File: rtl/serdiv3_bitcnt.sv
module serdiv3_bitcnt #(
   parameter int WIDTH = 8,
   localparam int CW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic adv_i,
   output logic last_o
);

   localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

   logic [CW-1:0] cnt_q, base, cnt_d;

   always_comb begin
      base   = clr_i ? '0 : cnt_q;
      last_o = (base == LAST);
      cnt_d  = base;
      if (adv_i) cnt_d = last_o ? '0 : base + CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

endmodule

// File: rtl/serial_div3_exact.sv
module serial_div3_exact
   import serdiv3_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter int STEP_STYLE = 0,
   parameter int REG_OUT    = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic bit_vld_i,
   input  logic bit_i,
   output logic q_vld_o,
   output logic q_o,
   output logic q_last_o,
   output logic ndiv_o
);

   initial begin
      assert (WIDTH >= 2) else $error("serial_div3_exact: WIDTH must be at least 2");
      assert (REG_OUT == 0 || REG_OUT == 1)
         else $error("serial_div3_exact: REG_OUT must be 0 or 1");
   end

   div3_state_e state_q, state_d, base_st, step_nxt;
   logic        qbit, last_bit, ndiv_q, ndiv_d;

   assign base_st = start_i ? ST_IDLE : state_q;

   serdiv3_step #(.STYLE(STEP_STYLE)) u_step (
      .cur_i  (base_st),
      .din_i  (bit_i),
      .nxt_o  (step_nxt),
      .qbit_o (qbit)
   );

   serdiv3_bitcnt #(.WIDTH(WIDTH)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (start_i),
      .adv_i  (bit_vld_i),
      .last_o (last_bit)
   );

   always_comb begin
      state_d = base_st;
      ndiv_d  = start_i ? 1'b0 : ndiv_q;
      if (bit_vld_i) begin
         state_d = last_bit ? ST_IDLE : step_nxt;
         if (last_bit) ndiv_d = (step_nxt != ST_IDLE);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ndiv_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         ndiv_q  <= ndiv_d;
      end
   end

   generate
      if (REG_OUT == 1) begin : g_reg
         logic vld_r, q_r, last_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_r  <= 1'b0;
               q_r    <= 1'b0;
               last_r <= 1'b0;
            end else begin
               vld_r  <= bit_vld_i;
               q_r    <= bit_vld_i & qbit;
               last_r <= bit_vld_i & last_bit;
            end
         end
         assign q_vld_o  = vld_r;
         assign q_o      = q_r;
         assign q_last_o = last_r;
         assign ndiv_o   = ndiv_q;
      end else begin : g_comb
         assign q_vld_o  = bit_vld_i;
         assign q_o      = bit_vld_i & qbit;
         assign q_last_o = bit_vld_i & last_bit;
         assign ndiv_o   = ndiv_d;
      end
   endgenerate

endmodule

// File: rtl/serial_div3_exact_chk.sv
module serial_div3_exact_chk #(
   parameter int REG_OUT = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       bit_vld_i,
   input logic       bit_i,
   input logic       q_vld_o,
   input logic       q_o,
   input logic       q_last_o,
   input logic       ndiv_o,
   input logic [1:0] state_q
);

   // R2: the unused encoding is never reached
   p_state_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != 2'b10);

   // R7: the word marker only rides on a valid quotient bit
   p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      q_last_o |-> q_vld_o);

   generate
      if (REG_OUT == 1) begin : g_reg_props
         // R3: one quotient bit per accepted bit, one cycle later
         p_vld_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
            bit_vld_i |=> q_vld_o);
         p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !bit_vld_i |=> !q_vld_o);
         // R2: polarity follows the state the bit was taken in
         p_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (q_vld_o && !$past(start_i)) |->
               (q_o == ($past(bit_i) ^ ($past(state_q) == 2'b01))));
         // R6: start clears the flag
         p_start_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
            start_i |=> !ndiv_o);
         // R5: flag is held when nothing happens
         p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!start_i && !bit_vld_i) |=> $stable(ndiv_o));
      end
   endgenerate

endmodule

bind serial_div3_exact serial_div3_exact_chk #(.REG_OUT(REG_OUT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .bit_vld_i (bit_vld_i),
   .bit_i     (bit_i),
   .q_vld_o   (q_vld_o),
   .q_o       (q_o),
   .q_last_o  (q_last_o),
   .ndiv_o    (ndiv_o),
   .state_q   (state_q)
);

// File: tb/serial_div3_exact_tb_top.sv
`timescale 1ns/1ps
module serial_div3_exact_tb_top;

   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b0;
   logic q_vld_o, q_o, q_last_o, ndiv_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   serial_div3_exact #(.WIDTH(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_vld_i(bit_vld_i),
      .bit_i(bit_i), .q_vld_o(q_vld_o), .q_o(q_o), .q_last_o(q_last_o),
      .ndiv_o(ndiv_o)
   );

   function automatic logic [W-1:0] exp_q(input logic [W-1:0] v);
      logic [2*W-1:0] p;
      p = {{W{1'b0}}, v} * (2*W)'(171);
      return p[W-1:0];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse_start();
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic run_word(input logic [W-1:0] v, input bit gaps, input bit with_start,
                           output logic [W-1:0] q, output logic flag);
      for (int i = 0; i < W; i++) begin
         if (gaps && ($urandom % 3 == 0)) begin
            bit_vld_i = 1'b0;
            @(negedge clk);
            check("R3 idle cycle q_vld_o", q_vld_o, 0);
         end
         bit_vld_i = 1'b1;
         bit_i     = v[i];
         start_i   = with_start && (i == 0);
         @(negedge clk);
         start_i = 1'b0;
         q[i] = q_o;
         if (q_vld_o !== 1'b1) check("R3 q_vld_o", q_vld_o, 1);
         if (q_last_o !== (i == W-1)) check("R7 q_last_o", q_last_o, (i == W-1));
      end
      bit_vld_i = 1'b0;
      flag = ndiv_o;
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] q;
      logic flag;
      void'($urandom(32'h5EED_0003));

      // R1 reset state
      @(negedge clk);
      check("R1 q_vld_o in reset", q_vld_o, 0);
      check("R1 ndiv_o in reset", ndiv_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 q_vld_o after reset", q_vld_o, 0);
      check("R1 q_last_o after reset", q_last_o, 0);
      check("R1 ndiv_o after reset", ndiv_o, 0);

      // R2 R4: 39 -> 13
      run_word(8'd39, 1'b0, 1'b0, q, flag);
      check("R4 39/3", q, 13);
      check("R5 39 flag", flag, 0);

      // R2: 5 walks through the high-state self loop -> 87, not divisible
      run_word(8'd5, 1'b0, 1'b0, q, flag);
      check("R2 quotient bits for 5", q, 87);
      check("R5 5 flag", flag, 1);

      // R5: flag held over idle cycles
      repeat (4) @(negedge clk);
      check("R5 flag held while idle", ndiv_o, 1);

      // R6: start clears the flag
      pulse_start();
      check("R6 start clears flag", ndiv_o, 0);

      // R6: start in the middle of a word, bit taken with start is bit 0
      for (int i = 0; i < 3; i++) begin
         bit_vld_i = 1'b1; bit_i = 1'b1;
         @(negedge clk);
      end
      run_word(8'd39, 1'b0, 1'b1, q, flag);
      check("R6 restart mid-word 39/3", q, 13);
      check("R6 restart mid-word flag", flag, 0);

      // R4 R5 R7 R8: exhaustive sweep, words chained without strobes
      for (int v = 0; v < (1 << W); v++) begin
         run_word(W'(v), 1'b0, 1'b0, q, flag);
         check("R8 quotient", q, exp_q(W'(v)));
         check("R5 flag", flag, (v % 3) != 0);
         if (v % 3 == 0) begin
            check("R4 exact quotient", q, v / 3);
            check("R4 top bit zero", q[W-1], 0);
         end
      end

      // R3 R8: random words with idle gaps
      for (int n = 0; n < 300; n++) begin
         logic [W-1:0] v;
         v = W'($urandom);
         if (n % 5 == 0) v = W'(3 * ($urandom % 86));
         run_word(v, 1'b1, 1'b0, q, flag);
         check("R8 random quotient", q, exp_q(v));
         check("R5 random flag", flag, (v % 3) != 0);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule